// File: doc/BRIEF.md
# Interrupt Status Collector

This unit gathers single-cycle event pulses from the command and data paths of a card host controller and latches each into a sticky bit of a 32-bit raw status register. A programmable mask selects which latched bits may raise the interrupt line, and a global enable gates that line as a whole. Software acknowledges events by writing ones to the raw status address. Each one written clears the matching bit.

Raw bits latch whether or not they are masked. A handler woken by one enabled event, such as command done, can still see error events that were left masked. Two summary outputs OR together the command-path error bits and the data-path error bits. A handler can then test one flag instead of decoding the whole word.

Bit positions are fixed because software decodes them. Bit 0 is card detect. Bit 1 is response error. Bit 2 is command done. Bit 3 is transfer over. Bits 4 and 5 are the transmit and receive FIFO requests. Bit 6 is response CRC error and bit 7 is data CRC error. Bit 8 is response timeout. Bit 9 is data read timeout. Bit 10 is starvation timeout. Bit 11 is FIFO over/underrun. Bit 12 is locked-while-error. Bit 13 is start-bit error. Bit 14 is auto-command done. Bit 15 is end-bit error. Bits 19:16 are the four SDIO lines. The other bits latch their event inputs but carry no meaning.

Top module: `intr_status_unit`

## Requirements
- R1: After the asynchronous active-low reset, raw status, mask, global enable and the interrupt line are all zero.
- R2: An event pulse on `evt_i[k]` sets `raw_o[k]` at the next rising clock edge. The bit stays set until it is cleared by a write.
- R3: A cycle with `wr_raw_i` high clears every raw bit whose `wdata_i` bit is 1 and leaves every bit whose `wdata_i` bit is 0 unchanged. Writing all ones clears the whole register.
- R4: When an event and a clear of the same bit occur in the same cycle, the bit is set afterwards.
- R5: `masked_o` equals `raw_o` AND `mask_o`. A raw bit latches even while its mask bit is 0.
- R6: A cycle with `wr_ctrl_i` high loads the global enable from bit 4 of `wdata_i` and ignores the other bits. `irq_o` is a register that is high one cycle after a cycle in which the enable was set and `masked_o` was nonzero.
- R7: Clearing the global enable drops `irq_o` and leaves the raw status unchanged.
- R8: `cmd_err_o` is high exactly when any of raw bits 1, 6, 8 or 12 is set.
- R9: `data_err_o` is high exactly when any of raw bits 7, 9, 10, 11, 12, 13 or 15 is set.
- R10: A cycle with `wr_mask_i` high loads `mask_o` from `wdata_i` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per status bit |
| wr_raw_i | input | 1 | Write-one-to-clear strobe for raw status |
| wr_mask_i | input | 1 | Mask register write strobe |
| wr_ctrl_i | input | 1 | Control write strobe (enable in bit 4) |
| wdata_i | input | 32 | Write data shared by the three strobes |
| raw_o | output | 32 | Latched raw status |
| mask_o | output | 32 | Current mask |
| masked_o | output | 32 | Raw status AND mask |
| irq_en_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Registered interrupt line |
| cmd_err_o | output | 1 | Command-path error summary |
| data_err_o | output | 1 | Data-path error summary |

## Verification
The properties assume that events are single-cycle pulses and that no event arrives while reset is asserted. If an event arrived during reset, the rule that a new raw bit needs an event in the previous cycle would depend on the value held during reset. The stimulus keeps every input at zero during reset. It changes inputs only at falling edges and holds each event and write strobe for exactly one cycle. Same-cycle collisions are driven on purpose only where a requirement covers them, as in the event-versus-clear case.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int STAT_W = 32;
  localparam int EN_BIT = 4;

  localparam int B_RESP_ERR  = 1;
  localparam int B_RESP_CRC  = 6;
  localparam int B_DATA_CRC  = 7;
  localparam int B_RESP_TO   = 8;
  localparam int B_RD_TO     = 9;
  localparam int B_STARVE_TO = 10;
  localparam int B_FIFO_RUN  = 11;
  localparam int B_LOCKED    = 12;
  localparam int B_START_BIT = 13;
  localparam int B_END_BIT   = 15;

  localparam logic [STAT_W-1:0] CMD_ERR_SEL =
      (STAT_W'(1) << B_RESP_ERR) | (STAT_W'(1) << B_RESP_CRC) |
      (STAT_W'(1) << B_RESP_TO)  | (STAT_W'(1) << B_LOCKED);

  localparam logic [STAT_W-1:0] DATA_ERR_SEL =
      (STAT_W'(1) << B_DATA_CRC)  | (STAT_W'(1) << B_RD_TO)     |
      (STAT_W'(1) << B_STARVE_TO) | (STAT_W'(1) << B_FIFO_RUN)  |
      (STAT_W'(1) << B_LOCKED)    | (STAT_W'(1) << B_START_BIT) |
      (STAT_W'(1) << B_END_BIT);
endpackage

// File: rtl/isu_raw_latch.sv
module isu_raw_latch #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // event has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q[i] <= 1'b0;
      else         raw_q[i] <= evt_i[i] | (raw_q[i] & ~(clr_en_i & clr_bits_i[i]));
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/isu_err_group.sv
module isu_err_group #(
  parameter int           W   = 32,
  parameter logic [W-1:0] SEL = '0
) (
  input  logic [W-1:0] raw_i,
  output logic         any_o
);
  assign any_o = |(raw_i & SEL);
endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen #(
  parameter int W      = 32,
  parameter int EN_POS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic         wr_mask_i,
  input  logic         wr_ctrl_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         en_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         en_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i;
      if (wr_ctrl_i) en_q   <= wdata_i[EN_POS];
    end
  end

  assign masked_o = raw_i & mask_q;

  // registered so the line never glitches on combinational paths
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_q & (|masked_o);
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit #(
  parameter int STAT_W = isu_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              wr_raw_i,
  input  logic              wr_mask_i,
  input  logic              wr_ctrl_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_en_o,
  output logic              irq_o,
  output logic              cmd_err_o,
  output logic              data_err_o
);
  localparam logic [STAT_W-1:0] CMD_SEL  = STAT_W'(isu_pkg::CMD_ERR_SEL);
  localparam logic [STAT_W-1:0] DATA_SEL = STAT_W'(isu_pkg::DATA_ERR_SEL);

  logic [STAT_W-1:0] raw;

  isu_raw_latch #(.W(STAT_W)) u_raw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_en_i   (wr_raw_i),
    .clr_bits_i (wdata_i),
    .raw_o      (raw)
  );

  isu_irq_gen #(.W(STAT_W), .EN_POS(isu_pkg::EN_BIT)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw),
    .wr_mask_i (wr_mask_i),
    .wr_ctrl_i (wr_ctrl_i),
    .wdata_i   (wdata_i),
    .mask_o    (mask_o),
    .masked_o  (masked_o),
    .en_o      (irq_en_o),
    .irq_o     (irq_o)
  );

  isu_err_group #(.W(STAT_W), .SEL(CMD_SEL)) u_cmd_err (
    .raw_i (raw),
    .any_o (cmd_err_o)
  );

  isu_err_group #(.W(STAT_W), .SEL(DATA_SEL)) u_data_err (
    .raw_i (raw),
    .any_o (data_err_o)
  );

  assign raw_o = raw;
endmodule

// File: rtl/intr_status_unit_chk.sv
module intr_status_unit_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] evt_i,
  input logic              wr_raw_i,
  input logic              wr_mask_i,
  input logic              wr_ctrl_i,
  input logic [STAT_W-1:0] wdata_i,
  input logic [STAT_W-1:0] raw_o,
  input logic [STAT_W-1:0] mask_o,
  input logic [STAT_W-1:0] masked_o,
  input logic              irq_en_o,
  input logic              irq_o
);
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i))); // R2

  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_o & ~$past(raw_o) & ~$past(evt_i)) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_raw_i |=> ((raw_o & $past(wdata_i) & ~$past(evt_i)) == '0)); // R3

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_raw_i && ((evt_i & wdata_i) != '0)) |=>
      ((raw_o & $past(evt_i & wdata_i)) == $past(evt_i & wdata_i))); // R4

  AST_IRQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == ($past(irq_en_o) && ($past(masked_o) != '0)))); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_o |=> !irq_o); // R7

  AST_CTRL_RAW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !wr_raw_i && (evt_i == '0)) |=> $stable(raw_o)); // R7

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (mask_o == $past(wdata_i))); // R10
endmodule

bind intr_status_unit intr_status_unit_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .wr_raw_i  (wr_raw_i),
  .wr_mask_i (wr_mask_i),
  .wr_ctrl_i (wr_ctrl_i),
  .wdata_i   (wdata_i),
  .raw_o     (raw_o),
  .mask_o    (mask_o),
  .masked_o  (masked_o),
  .irq_en_o  (irq_en_o),
  .irq_o     (irq_o)
);

// File: tb/sim_intr_status_unit.sv
module sim_intr_status_unit;
  localparam int CLK_P = 10;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] evt;
    logic         wr_raw;
    logic         wr_mask;
    logic         wr_ctrl;
    logic [W-1:0] wdata;
    logic [W-1:0] exp_raw;
    logic [W-1:0] exp_masked;
    logic         exp_en;
    logic         exp_irq;
    logic         exp_cmd;
    logic         exp_data;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h4,      0,0,0, 32'h0,        32'h4,     32'h0, 0,0,0,0}, // R2 cmd done
    '{32'h0,      0,1,0, 32'hC,        32'h4,     32'h4, 0,0,0,0}, // R10 R5
    '{32'h0,      0,0,1, 32'h10,       32'h4,     32'h4, 1,1,0,0}, // R6
    '{32'h102,    0,0,0, 32'h0,        32'h106,   32'h4, 1,1,1,0}, // R5 masked latch, R8
    '{32'h0,      1,0,0, 32'h4,        32'h102,   32'h0, 1,0,1,0}, // R3
    '{32'h8000,   0,0,0, 32'h0,        32'h8102,  32'h0, 1,0,1,1}, // R9
    '{32'h0,      1,0,0, 32'h0,        32'h8102,  32'h0, 1,0,1,1}, // R3 zeros
    '{32'h8,      0,0,0, 32'h0,        32'h810A,  32'h8, 1,1,1,1}, // R6
    '{32'h0,      0,0,1, 32'h0,        32'h810A,  32'h8, 0,0,1,1}, // R7
    '{32'h0,      0,0,1, 32'hFFFFFFEF, 32'h810A,  32'h8, 0,0,1,1}, // R6 only bit 4
    '{32'h0,      0,0,1, 32'h10,       32'h810A,  32'h8, 1,1,1,1}, // R6
    '{32'h0,      1,0,0, 32'hFFFFFFFF, 32'h0,     32'h0, 1,0,0,0}, // R3 all ones
    '{32'h1000,   0,0,0, 32'h0,        32'h1000,  32'h0, 1,0,1,1}, // R8 R9 shared bit
    '{32'h0,      1,0,0, 32'h1000,     32'h0,     32'h0, 1,0,0,0}, // R3
    '{32'hF0000,  0,0,0, 32'h0,        32'hF0000, 32'h0, 1,0,0,0}, // R2 SDIO
    '{32'h0,      1,0,0, 32'hFFFFFFFF, 32'h0,     32'h0, 1,0,0,0}  // R3
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] evt_i = '0;
  logic         wr_raw_i = 1'b0;
  logic         wr_mask_i = 1'b0;
  logic         wr_ctrl_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] raw_o, mask_o, masked_o;
  logic         irq_en_o, irq_o, cmd_err_o, data_err_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  intr_status_unit u0 (
    .clk_i, .rst_ni, .evt_i, .wr_raw_i, .wr_mask_i, .wr_ctrl_i, .wdata_i,
    .raw_o, .mask_o, .masked_o, .irq_en_o, .irq_o, .cmd_err_o, .data_err_o
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_i = '0; wr_raw_i = 0; wr_mask_i = 0; wr_ctrl_i = 0; wdata_i = '0;
  endtask

  // drive one cycle, idle one cycle, sample at the following falling edge
  task automatic step(input logic [W-1:0] e, input logic wr, input logic wm,
                      input logic wc, input logic [W-1:0] d);
    @(negedge clk_i);
    evt_i = e; wr_raw_i = wr; wr_mask_i = wm; wr_ctrl_i = wc; wdata_i = d;
    @(negedge clk_i);
    idle();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 raw", raw_o, '0);
    chk("R1 mask", mask_o, '0);
    chk("R1 en", W'(irq_en_o), '0);
    chk("R1 irq", W'(irq_o), '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].evt, VECS[i].wr_raw, VECS[i].wr_mask, VECS[i].wr_ctrl, VECS[i].wdata);
      chk("R2 raw", raw_o, VECS[i].exp_raw);
      chk("R5 masked", masked_o, VECS[i].exp_masked);
      chk("R6 en", W'(irq_en_o), W'(VECS[i].exp_en));
      chk("R6 irq", W'(irq_o), W'(VECS[i].exp_irq));
      chk("R8 cmd", W'(cmd_err_o), W'(VECS[i].exp_cmd));
      chk("R9 data", W'(data_err_o), W'(VECS[i].exp_data));
    end

    // R10 mask readback
    step('0, 0, 1, 0, 32'hA5A5_0F0F);
    chk("R10 mask", mask_o, 32'hA5A5_0F0F);

    // R4 event and clear of same bit in one cycle
    step(32'h200, 1, 0, 0, 32'h200);
    chk("R4 collide", raw_o, 32'h200);
    step('0, 1, 0, 0, 32'hFFFFFFFF);
    chk("R3 clear", raw_o, '0);

    // R6 irq one cycle after raw
    step('0, 0, 1, 0, 32'h8);
    @(negedge clk_i);
    evt_i = 32'h8;
    @(negedge clk_i);
    idle();
    chk("R2 raw first", raw_o, 32'h8);
    chk("R6 irq lag", W'(irq_o), '0);
    @(negedge clk_i);
    chk("R6 irq up", W'(irq_o), 1);

    // R7 disable drops irq, keeps raw
    step('0, 0, 0, 1, 32'h0);
    chk("R7 irq off", W'(irq_o), '0);
    chk("R7 raw kept", raw_o, 32'h8);
    step('0, 1, 0, 0, 32'hFFFFFFFF);

    // R8 R9 per-bit summaries
    for (int b = 0; b < 20; b++) begin
      logic ec, ed;
      ec = (b == 1) || (b == 6) || (b == 8) || (b == 12);
      ed = (b == 7) || (b == 9) || (b == 10) || (b == 11) || (b == 12) ||
           (b == 13) || (b == 15);
      step(W'(1) << b, 0, 0, 0, '0);
      chk("R8 bit", W'(cmd_err_o), W'(ec));
      chk("R9 bit", W'(data_err_o), W'(ed));
      step('0, 1, 0, 0, W'(1) << b);
      chk("R3 bit clear", raw_o, '0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule